// File: doc/BRIEF.md
# Expansion Slot Firmware ROM Window Decoder

This block sits on a peripheral card for an 8-bit, 1 MHz expansion slot and decides when the card's 4 KB firmware ROM drives the bus, and which ROM byte it drives. The slot provides two pre-decoded strobes. The first selects the card's private 256-byte page at $Cn00-$CnFF, where n is the slot number. The second is shared by every slot and covers the 2 KB expansion window at $C800-$CFFF.

The lower half of the ROM holds eight 256-byte page images, one per slot. The slot number picks the image, so the same card serves different page code in each slot. The upper half of the ROM backs the shared window. The card answers in the shared window only while an ownership flag is set. Any access to the card's own page sets this flag. Any access to $CFFF clears it, which hands the window back to other cards.

The ROM is a synchronous lookup. Its byte appears one clock after an enabled read, well inside the roughly 400 ns during which address and selects are valid. The decoder is clocked by a fast card clock, and each clock edge samples the bus signals once.

Top module: `slot_rom_window`

## Requirements
- R1: After reset (`rst_n` low, asynchronous) the ownership flag is clear, so a shared-window read with `page_sel` low keeps `rom_oe` low. `rom_valid` is low.
- R2: A read with `page_sel` high drives `rom_oe` high in the same cycle, with `rom_addr` = {1'b0, `slot_id`, `bus_addr[7:0]`}.
- R3: Any cycle with `page_sel` high, whether read or write, sets the ownership flag from the next cycle on.
- R4: A read with `win_strobe` high, `page_sel` low and the flag set drives `rom_oe` high, with `rom_addr` = {1'b1, `bus_addr[10:0]`}.
- R5: A shared-window access with the flag clear never drives `rom_oe` high.
- R6: A `win_strobe` cycle with `bus_addr` all ones (address $CFFF) and `page_sel` low clears the flag from the next cycle on. If the flag was set, a read in that same cycle is still served.
- R7: When `page_sel` and a $CFFF strobe are high in the same cycle, the flag ends up set. The page access takes priority for `rom_addr` as well.
- R8: A write cycle (`rd_cycle` low) never drives `rom_oe` high.
- R9: One cycle after a cycle with `rom_oe` high, `rom_valid` is high for one cycle and `rom_data` = ((A mod 256) XOR ((A div 256) * 23)) mod 256, where A is the `rom_addr` of that read. `rom_valid` is low after any other cycle.
- R10: A shared-window access to any address other than $CFFF, with `page_sel` low, leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock, samples the bus once per edge |
| rst_n | input | 1 | Asynchronous active-low system reset |
| page_sel | input | 1 | Per-slot page strobe, active high |
| win_strobe | input | 1 | Shared 2 KB window strobe, active high |
| rd_cycle | input | 1 | High for a read cycle, low for a write cycle |
| bus_addr | input | 11 | Low address lines A10..A0 |
| slot_id | input | 3 | Slot number the card occupies |
| rom_addr | output | 12 | ROM address for the current access |
| rom_oe | output | 1 | ROM output enable for the current access |
| rom_data | output | 8 | ROM byte of the last enabled read |
| rom_valid | output | 1 | High in the cycle after an enabled read |

## Verification
The bench builds the block with the default widths: 3 slot bits, 8 page bits and 11 window bits. With these widths the page images for slots 0, 2, 5 and 7 and the all-ones window address $CFFF can all be reached directly. The bench runs through the flag's full life: cleared by reset, set by a page write, kept across ordinary window reads and writes, and released at $CFFF. It also checks the collision case, where a page access and the release address occur in the same cycle.

// File: rtl/slot_rom_pkg.sv
package slot_rom_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PAGE = 2'd1,
    SRC_WIN  = 2'd2
  } rom_src_e;

  // Computed ROM content: low address byte mixed with a scaled high part
  function automatic logic [31:0] rom_word(input logic [31:0] a);
    logic [31:0] t;
    t = (a & 32'h0000_00FF) ^ ((a >> 8) * 32'd23);
    return t;
  endfunction

endpackage

// File: rtl/window_owner.sv
module window_owner #(
  parameter int WIN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             page_hit,
  input  logic             win_hit,
  input  logic [WIN_W-1:0] win_addr,
  output logic             own_q
);
  logic release_hit;

  assign release_hit = win_hit && (&win_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= 1'b0;
    end else if (page_hit) begin
      own_q <= 1'b1;
    end else if (release_hit) begin
      own_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rom_route.sv
module rom_route
  import slot_rom_pkg::*;
#(
  parameter int SLOT_W = 3,
  parameter int PAGE_W = 8,
  parameter int WIN_W  = 11,
  localparam int ROM_AW = WIN_W + 1
) (
  input  logic              page_hit,
  input  logic              win_hit,
  input  logic              own,
  input  logic              rd,
  input  logic [SLOT_W-1:0] slot,
  input  logic [WIN_W-1:0]  addr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              oe
);
  rom_src_e          src;
  logic [ROM_AW-1:0] page_addr;
  logic [ROM_AW-1:0] win_addr;

  generate
    if (SLOT_W + PAGE_W == WIN_W) begin : g_exact
      assign page_addr = {1'b0, slot, addr[PAGE_W-1:0]};
    end else begin : g_pad
      localparam int PAD_W = WIN_W - SLOT_W - PAGE_W;
      assign page_addr = {1'b0, {PAD_W{1'b0}}, slot, addr[PAGE_W-1:0]};
    end
  endgenerate

  assign win_addr = {1'b1, addr};

  always_comb begin
    if (page_hit)             src = SRC_PAGE;
    else if (win_hit && own)  src = SRC_WIN;
    else                      src = SRC_NONE;
  end

  always_comb begin
    unique case (src)
      SRC_PAGE: rom_addr = page_addr;
      SRC_WIN:  rom_addr = win_addr;
      default:  rom_addr = '0;
    endcase
    oe = rd && (src != SRC_NONE);
  end
endmodule

// File: rtl/rom_lookup.sv
module rom_lookup
  import slot_rom_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data,
  output logic          valid
);
  logic [31:0] word;

  assign word = rom_word(32'(addr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= en;
      if (en) data <= word[DW-1:0];
    end
  end
endmodule

// File: rtl/slot_rom_window.sv
module slot_rom_window #(
  parameter int SLOT_W = 3,
  parameter int PAGE_W = 8,
  parameter int WIN_W  = 11,
  parameter int DW     = 8,
  localparam int ROM_AW = WIN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_sel,
  input  logic              win_strobe,
  input  logic              rd_cycle,
  input  logic [WIN_W-1:0]  bus_addr,
  input  logic [SLOT_W-1:0] slot_id,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_oe,
  output logic [DW-1:0]     rom_data,
  output logic              rom_valid
);
  logic own_q;

  window_owner #(.WIN_W(WIN_W)) u_owner (
    .clk      (clk),
    .rst_n    (rst_n),
    .page_hit (page_sel),
    .win_hit  (win_strobe),
    .win_addr (bus_addr),
    .own_q    (own_q)
  );

  rom_route #(.SLOT_W(SLOT_W), .PAGE_W(PAGE_W), .WIN_W(WIN_W)) u_route (
    .page_hit (page_sel),
    .win_hit  (win_strobe),
    .own      (own_q),
    .rd       (rd_cycle),
    .slot     (slot_id),
    .addr     (bus_addr),
    .rom_addr (rom_addr),
    .oe       (rom_oe)
  );

  rom_lookup #(.AW(ROM_AW), .DW(DW)) u_rom (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (rom_oe),
    .addr  (rom_addr),
    .data  (rom_data),
    .valid (rom_valid)
  );
endmodule

// File: rtl/slot_rom_window_chk.sv
module slot_rom_window_chk #(
  parameter int WIN_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             page_sel,
  input logic             win_strobe,
  input logic             rd_cycle,
  input logic [WIN_W-1:0] bus_addr,
  input logic             rom_oe,
  input logic             rom_valid,
  input logic             own
);
  logic top_hit;
  assign top_hit = win_strobe && (&bus_addr);

  a_r3_page_sets_owner: assert property (@(posedge clk) disable iff (!rst_n)
    page_sel |=> own);
  a_r6_top_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (top_hit && !page_sel) |=> !own);
  a_r10_owner_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!page_sel && !top_hit) |=> (own == $past(own)));
  a_r8_no_oe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cycle |-> !rom_oe);
  a_r5_no_oe_unowned: assert property (@(posedge clk) disable iff (!rst_n)
    (!page_sel && !own) |-> !rom_oe);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rom_oe |=> rom_valid);
  a_r9_valid_only_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe |=> !rom_valid);
endmodule

bind slot_rom_window slot_rom_window_chk #(.WIN_W(WIN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .page_sel   (page_sel),
  .win_strobe (win_strobe),
  .rd_cycle   (rd_cycle),
  .bus_addr   (bus_addr),
  .rom_oe     (rom_oe),
  .rom_valid  (rom_valid),
  .own        (own_q)
);

// File: tb/tb_slot_rom_window.sv
module tb_slot_rom_window;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        page_sel = 1'b0;
  logic        win_strobe = 1'b0;
  logic        rd_cycle = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [2:0]  slot_id = '0;
  logic [11:0] rom_addr;
  logic        rom_oe;
  logic [7:0]  rom_data;
  logic        rom_valid;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit model_own = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_rom_window dut (
    .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .win_strobe(win_strobe),
    .rd_cycle(rd_cycle), .bus_addr(bus_addr), .slot_id(slot_id),
    .rom_addr(rom_addr), .rom_oe(rom_oe), .rom_data(rom_data), .rom_valid(rom_valid)
  );

  function automatic logic [7:0] exp_byte(input int a);
    int t;
    t = (a % 256) ^ ((a / 256) * 23);
    return t[7:0];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Driver: apply one bus cycle, check combinational outputs, queue expected data
  task automatic access(input string req, input bit ps, input bit ws, input bit rd,
                        input int addr, input int slot);
    bit exp_oe;
    int exp_addr;
    @(negedge clk);
    page_sel = ps; win_strobe = ws; rd_cycle = rd;
    bus_addr = 11'(addr); slot_id = 3'(slot);
    #1;
    if (ps) exp_addr = ((slot % 8) << 8) | (addr % 256);
    else if (ws && model_own) exp_addr = 2048 | (addr % 2048);
    else exp_addr = 0;
    exp_oe = rd && (ps || (ws && model_own));
    check({req, " oe"}, int'(rom_oe), int'(exp_oe));
    if (exp_oe) begin
      check({req, " addr"}, int'(rom_addr), exp_addr);
      exp_q.push_back(exp_byte(exp_addr));
    end
    if (ps) model_own = 1;
    else if (ws && (addr % 2048) == 2047) model_own = 0;
  endtask

  task automatic idle();
    @(negedge clk);
    page_sel = 0; win_strobe = 0; rd_cycle = 0;
  endtask

  // Monitor: after each edge compare produced data against the queue (R9)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        if (exp_q.size() > 0) begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check("R9 valid", int'(rom_valid), 1);
          check("R9 data", int'(rom_data), int'(e));
        end else begin
          check("R9 idle valid", int'(rom_valid), 0);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset oe", int'(rom_oe), 0);
    check("R1 reset valid", int'(rom_valid), 0);
    rst_n = 1;
    access("R1 window after reset", 0, 1, 1, 11'h000, 0);
    access("R2 slot5 page read", 1, 0, 1, 8'h34, 5);
    access("R4 window read owned", 0, 1, 1, 11'h123, 5);
    access("R6 top read served", 0, 1, 1, 11'h7FF, 5);
    access("R6 window after release", 0, 1, 1, 11'h100, 5);
    access("R8 page write", 1, 0, 0, 8'h10, 2);
    access("R8 window write", 0, 1, 0, 11'h200, 2);
    access("R10 window read kept", 0, 1, 1, 11'h200, 2);
    access("R10 window read 7FE", 0, 1, 1, 11'h7FE, 2);
    access("R7 collision read", 1, 1, 1, 11'h7FF, 7);
    access("R7 window after collision", 0, 1, 1, 11'h050, 7);
    access("R2 slot0 page read", 1, 0, 1, 8'hFF, 0);
    access("R6 top write release", 0, 1, 0, 11'h7FF, 0);
    access("R5 window unowned", 0, 1, 1, 11'h3AB, 0);
    idle();
    idle();
    access("R3 page write arms", 1, 0, 0, 8'h00, 3);
    access("R4 window read after write arm", 0, 1, 1, 11'h6C1, 3);
    idle();
    rst_n = 0;
    model_own = 0;
    repeat (2) @(negedge clk);
    #1;
    check("R1 mid reset valid", int'(rom_valid), 0);
    rst_n = 1;
    access("R1 window after second reset", 0, 1, 1, 11'h6C1, 3);
    idle();
    idle();
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R9: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule